// File: doc/BRIEF.md
# Bunch Veto Serial Link

This block sends bunch veto messages over one fast serial line and receives them again. Both halves run on the same 100 MHz clock. On the send side, a valid/ready request port takes a 12-bit bunch number and a small reserved field. The sender turns each request into a fixed-length frame on the line. The frame has a 2-bit header of two ones, then the bunch number, then the reserved bits, and every field goes out most significant bit first. With the default reserved width of 6, the frame is 20 bits long. It therefore lasts 200 ns, which is one bunch period. The reserved width can be set as low as 4, which gives an 18-bit frame.

The receive side watches a line input. It finds two consecutive ones while idle and then collects the payload. It presents the bunch number and the reserved bits with a one-cycle strobe. A bunch number that cannot occur in a train (3000 or above) raises an error strobe instead of the valid strobe. The send line and the receive line are separate ports, so the two halves can be looped back or used at the two ends of a link.

The sender has two states. In TX_IDLE it is ready; an accepted request moves it to TX_SEND. After the last frame bit it returns to TX_IDLE. The receiver has three states:
- RX_IDLE moves to RX_HEAD on a one.
- RX_HEAD moves to RX_BODY on a second one, or falls back to RX_IDLE on a zero.
- RX_BODY returns to RX_IDLE after the last payload bit and emits the result.

Top module: `veto_link`

## Requirements
- R1: An accepted request produces exactly 2+12+RSV_W line bits on the cycles that follow the accepting edge: 1, 1, then the bunch number MSB first, then the reserved field MSB first.
- R2: The send line is 0 whenever no frame is in flight.
- R3: req_ready is low for every cycle of a frame and high on the cycle after the last bit. A request presented on that cycle is accepted, and its header starts on the next cycle.
- R4: After the last payload bit is sampled, the receiver raises exactly one strobe (det_valid or det_error) for one cycle, together with the bunch number and the reserved field. For a looped-back frame, the strobe is visible in the cycle after the last line bit.
- R5: A received bunch number of 3000 or above raises det_error and not det_valid. A bunch number of 2999 or below raises det_valid and not det_error.
- R6: A single 1 followed by a 0 on the receive line is not a header: no strobe results, and a real frame that follows is still decoded.
- R7: While a frame payload is being collected, patterns of consecutive ones inside it are not taken as a new header, so frames sent back to back decode correctly.
- R8: The reserved bits reach det_rsv unchanged.
- R9: With RSV_W set to 4, the frame is 18 bits and decodes correctly. Settings that exceed 20 bits or go below 4 reserved bits are rejected at elaboration.
- R10: During reset, req_ready is 1 and tx_line, det_valid and det_error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Veto request present |
| req_ready | output | 1 | Sender can accept a request |
| req_bunch | input | 12 | Bunch number to send |
| req_rsv | input | RSV_W | Reserved payload to send |
| tx_line | output | 1 | Serial send line, idle 0 |
| rx_line | input | 1 | Serial receive line |
| det_valid | output | 1 | One-cycle strobe: valid bunch decoded |
| det_error | output | 1 | One-cycle strobe: out-of-range bunch decoded |
| det_bunch | output | 12 | Decoded bunch number |
| det_rsv | output | RSV_W | Decoded reserved payload |

## Verification
The bench goes after the range limit on both sides of 3000. A receiver that compared with the wrong bound, or with <= instead of <, would flag bunch 2999 or pass bunch 3000. It injects a lone 1 ahead of a real frame: a receiver that committed to a header on one bit would shift the payload by one place. It sends payloads full of adjacent ones back to back with the one-cycle gap: a receiver that kept looking for headers mid-frame would restart in the middle of the payload. A sender whose ready returned one cycle late, or whose count was off by one, shows up in the captured bit pattern and in the strobe timing.

// File: rtl/veto_link_pkg.sv
package veto_link_pkg;
    localparam int HDR_W = 2;
    localparam logic [1:0] HDR_CODE = 2'b11;
    localparam int FRAME_LIMIT = 20;
    localparam int RSV_MIN = 4;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HEAD,
        RX_BODY
    } rx_state_e;
endpackage

// File: rtl/veto_frame_tx.sv
module veto_frame_tx
    import veto_link_pkg::*;
#(
    parameter int BUNCH_W = 12,
    parameter int RSV_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BUNCH_W-1:0] req_bunch,
    input  logic [RSV_W-1:0]   req_rsv,
    output logic               line_o
);
    localparam int FRAME_W = HDR_W + BUNCH_W + RSV_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    tx_state_e          state, state_nxt;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bits_left;
    logic               accept;
    logic               last_bit;

    assign accept   = req_valid && req_ready;
    assign last_bit = (bits_left == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_IDLE: if (accept)   state_nxt = TX_SEND;
            TX_SEND: if (last_bit) state_nxt = TX_IDLE;
        endcase
    end

    // frame shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (accept) begin
            shreg     <= {HDR_CODE, req_bunch, req_rsv};
            bits_left <= CNT_W'(FRAME_W - 1);
        end else if (state == TX_SEND) begin
            shreg     <= {shreg[FRAME_W-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == TX_IDLE);
        line_o    = (state == TX_SEND) && shreg[FRAME_W-1];
    end

    // R1
    hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> line_o);

    // R3
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: rtl/veto_frame_rx.sv
module veto_frame_rx
    import veto_link_pkg::*;
#(
    parameter int BUNCH_W   = 12,
    parameter int RSV_W     = 6,
    parameter int MAX_BUNCH = 3000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_i,
    output logic               out_valid,
    output logic               out_error,
    output logic [BUNCH_W-1:0] out_bunch,
    output logic [RSV_W-1:0]   out_rsv
);
    localparam int PAY_W = BUNCH_W + RSV_W;
    localparam int CNT_W = $clog2(PAY_W);

    rx_state_e        state, state_nxt;
    logic [PAY_W-1:0] shreg;
    logic [PAY_W-1:0] payload;
    logic [CNT_W-1:0] bits_left;
    logic             body_done;
    logic [BUNCH_W-1:0] bunch_w;
    logic             in_range;

    assign body_done = (state == RX_BODY) && (bits_left == '0);
    assign payload   = {shreg[PAY_W-2:0], line_i};
    assign bunch_w   = payload[PAY_W-1 -: BUNCH_W];
    assign in_range  = int'(bunch_w) < MAX_BUNCH;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE: if (line_i)    state_nxt = RX_HEAD;
            RX_HEAD: state_nxt = line_i ? RX_BODY : RX_IDLE;
            RX_BODY: if (body_done) state_nxt = RX_IDLE;
            default: state_nxt = RX_IDLE;
        endcase
    end

    // payload collection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (state == RX_HEAD && line_i) begin
            bits_left <= CNT_W'(PAY_W - 1);
        end else if (state == RX_BODY) begin
            shreg     <= payload;
            bits_left <= bits_left - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_error <= 1'b0;
            out_bunch <= '0;
            out_rsv   <= '0;
        end else begin
            out_valid <= body_done && in_range;
            out_error <= body_done && !in_range;
            if (body_done) begin
                out_bunch <= bunch_w;
                out_rsv   <= payload[RSV_W-1:0];
            end
        end
    end

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_error) |=> !(out_valid || out_error));

    // R4
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_error) |-> $past(state) == RX_BODY);

    // R6
    head_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HEAD && !line_i) |=> state == RX_IDLE);
endmodule

// File: rtl/veto_link.sv
module veto_link
    import veto_link_pkg::*;
#(
    parameter int BUNCH_W   = 12,
    parameter int RSV_W     = 6,
    parameter int MAX_BUNCH = 3000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BUNCH_W-1:0] req_bunch,
    input  logic [RSV_W-1:0]   req_rsv,
    output logic               tx_line,
    input  logic               rx_line,
    output logic               det_valid,
    output logic               det_error,
    output logic [BUNCH_W-1:0] det_bunch,
    output logic [RSV_W-1:0]   det_rsv
);
    // R9: frame must fit one bunch period and keep the minimum reserved width
    if (HDR_W + BUNCH_W + RSV_W > FRAME_LIMIT || RSV_W < RSV_MIN) begin : g_bad_cfg
        $error("veto_link: frame width configuration out of range");
    end

    veto_frame_tx #(
        .BUNCH_W (BUNCH_W),
        .RSV_W   (RSV_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_bunch (req_bunch),
        .req_rsv   (req_rsv),
        .line_o    (tx_line)
    );

    veto_frame_rx #(
        .BUNCH_W   (BUNCH_W),
        .RSV_W     (RSV_W),
        .MAX_BUNCH (MAX_BUNCH)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (rx_line),
        .out_valid (det_valid),
        .out_error (det_error),
        .out_bunch (det_bunch),
        .out_rsv   (det_rsv)
    );
endmodule

// File: tb/sim_veto_link.sv
module sim_veto_link;
    localparam int BW  = 12;
    localparam int RW  = 6;
    localparam int FW  = 2 + BW + RW;
    localparam int RW4 = 4;
    localparam int FW4 = 2 + BW + RW4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [BW-1:0] req_bunch;
    logic [RW-1:0] req_rsv;
    logic          tx_line;
    logic          rx_line;
    logic          det_valid, det_error;
    logic [BW-1:0] det_bunch;
    logic [RW-1:0] det_rsv;
    logic          inj_en, inj_bit;

    assign rx_line = inj_en ? inj_bit : tx_line;

    veto_link u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bunch(req_bunch), .req_rsv(req_rsv),
        .tx_line(tx_line), .rx_line(rx_line),
        .det_valid(det_valid), .det_error(det_error),
        .det_bunch(det_bunch), .det_rsv(det_rsv)
    );

    logic           v1_valid, v1_ready, v1_line, v1_dvalid, v1_derr;
    logic [BW-1:0]  v1_bunch, v1_dbunch;
    logic [RW4-1:0] v1_rsv, v1_drsv;

    veto_link #(.RSV_W(RW4)) u1 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(v1_valid), .req_ready(v1_ready),
        .req_bunch(v1_bunch), .req_rsv(v1_rsv),
        .tx_line(v1_line), .rx_line(v1_line),
        .det_valid(v1_dvalid), .det_error(v1_derr),
        .det_bunch(v1_dbunch), .det_rsv(v1_drsv)
    );

    typedef struct packed {
        logic          err;
        logic [BW-1:0] bunch;
        logic [RW-1:0] rsv;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    int   unexpected = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: call at a negedge; returns at the negedge of the gap cycle
    task automatic send(input logic [BW-1:0] b, input logic [RW-1:0] r);
        logic [FW-1:0] pat;
        logic [FW-1:0] want;
        bit            rdy_high;
        exp_t          e;
        rdy_high = 1'b0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_bunch = b;
        req_rsv   = r;
        e.err   = (int'(b) >= 3000);
        e.bunch = b;
        e.rsv   = r;
        q.push_back(e);
        want = {2'b11, b, r};
        @(posedge clk);
        for (int i = 0; i < FW; i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            pat[FW-1-i] = tx_line;
            if (req_ready) rdy_high = 1'b1;
        end
        chk(pat == want, "R1 frame bits", 32'(pat), 32'(want));
        chk(!rdy_high, "R3 ready low during frame", 32'(rdy_high), 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R3 ready after last bit", 32'(req_ready), 1);
        chk(tx_line == 1'b0, "R2 idle line", 32'(tx_line), 0);
        chk((det_valid || det_error) == 1'b1, "R4 strobe timing", 32'(det_valid || det_error), 1);
    endtask

    task automatic inject(input logic [31:0] v, input int n);
        inj_en = 1'b1;
        for (int i = n - 1; i >= 0; i--) begin
            inj_bit = v[i];
            @(negedge clk);
        end
        inj_bit = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (det_valid || det_error)) begin
            if (q.size() == 0) begin
                unexpected++;
                chk(1'b0, "R6 unexpected strobe", 32'(det_bunch), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(det_error == e.err, "R5 error strobe", 32'(det_error), 32'(e.err));
                chk(det_valid == !e.err, "R5 valid strobe", 32'(det_valid), 32'(!e.err));
                chk(det_bunch == e.bunch, "R4 bunch", 32'(det_bunch), 32'(e.bunch));
                chk(det_rsv == e.rsv, "R8 reserved", 32'(det_rsv), 32'(e.rsv));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0;
        req_valid = 1'b0; req_bunch = '0; req_rsv = '0;
        inj_en = 1'b0; inj_bit = 1'b0;
        v1_valid = 1'b0; v1_bunch = '0; v1_rsv = '0;
        repeat (3) @(negedge clk);
        // R10
        chk(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 1);
        chk(tx_line == 1'b0, "R10 line in reset", 32'(tx_line), 0);
        chk(det_valid == 1'b0, "R10 valid in reset", 32'(det_valid), 0);
        chk(det_error == 1'b0, "R10 error in reset", 32'(det_error), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_line == 1'b0, "R2 idle after reset", 32'(tx_line), 0);

        send(12'd0, 6'h00);
        send(12'd2999, 6'h3F);       // R5 upper valid bound
        send(12'd3000, 6'h15);       // R5 first invalid
        send(12'd4095, 6'h00);       // R5
        send(12'd1755, 6'b110111);   // R7 payload of adjacent ones, back to back
        send(12'd1, 6'h2A);          // R3 accepted in gap cycle
        send(12'd2048, 6'h01);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R4 all frames decoded", 32'(q.size()), 0);

        // R6: lone one, then silence
        inject(32'b10, 2);
        inject(32'd0, 25);
        chk(unexpected == 0 && q.size() == 0, "R6 lone one ignored", 32'(unexpected), 0);

        // R6 / R7: lone one directly ahead of a real frame
        begin
            exp_t e;
            e.err = 1'b0; e.bunch = 12'd100; e.rsv = 6'd5;
            q.push_back(e);
        end
        inject({10'd0, 2'b10, 2'b11, 12'd100, 6'd5}, 22);
        inject(32'd0, 4);
        chk(q.size() == 0, "R6 frame after lone one", 32'(q.size()), 0);
        inj_en = 1'b0;

        // R9: reduced reserved width instance
        v1_valid = 1'b1; v1_bunch = 12'd2999; v1_rsv = 4'hA;
        @(posedge clk);
        n = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (i == 1) v1_valid = 1'b0;
            if (v1_dvalid) begin n = i; break; end
        end
        chk(n == FW4 + 1, "R9 short frame timing", 32'(n), 32'(FW4 + 1));
        chk(v1_dbunch == 12'd2999, "R9 short frame bunch", 32'(v1_dbunch), 2999);
        chk(v1_drsv == 4'hA, "R9 short frame reserved", 32'(v1_drsv), 32'hA);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule